// File: doc/BRIEF.md
# Stub Cache Controller Register File

This block is a memory-mapped register file that stands in for a second-level cache controller. Driver software can program it, read its identification and configuration back, and poll maintenance operations, and no cache stands behind it. It decodes a 4 KiB window on a simple bus. Each cycle the bus carries an address, a read strobe, a write strobe and 32-bit write data. Read data is returned combinationally in the same cycle.

The block holds a fixed identification word and a type word. It also holds control, auxiliary control, tag and data latency settings, and an address-filter window. Every maintenance operation reads back as already finished. A read of the type word merges fields of the auxiliary control register into it. Bits set this way stay set until the type word is reloaded.

The block has two resets. The power-on reset clears everything. The warm reset clears the configuration registers and leaves the type word alone. A separate reload input restores the type word's default. An access to an offset that nothing decodes raises a one-cycle flag. It also increments a saturating counter, so a test environment can see stray driver accesses.

Top module: `cache_ctl_stub`

## Requirements
- R1: Only `bus_addr[11:0]` is decoded. Every address with the same low 12 bits behaves identically.
- R2: A read of offset 0x000 returns 0x410000C8. A write there is ignored and counts as a bad access.
- R3: Power-on reset (`por_n` low) sets the type word to `TYPE_DEFAULT` (0x1C100100). Warm reset (`rst_n` low) leaves the type word unchanged. `type_reload` high at a clock edge sets the type word back to `TYPE_DEFAULT`. A write to offset 0x004 is ignored and counts as a bad access.
- R4: A read of offset 0x004 forms a 5-bit code c = {aux[19:17], 1'b0, aux[16]}. It returns the stored type word ORed with (c << 18) | (c << 6), and it stores that result at the clock edge. Unless `type_reload` is high at that edge, bits set by earlier reads stay set.
- R5: A write to control (0x100) keeps only data bit 0. Bits 31:1 of control always read as zero.
- R6: Auxiliary control (0x104), tag latency (0x108), data latency (0x10C), filter start (0xC00) and filter end (0xC04) are full 32-bit read/write registers.
- R7: Either reset clears control, tag latency, data latency, filter start and filter end, and sets auxiliary control to 0x02020000.
- R8: Any read at an offset from 0x730 up to and including 0x7FF returns zero, meaning "operation complete". Writes there are ignored, and no access in that range counts as bad.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as zero and ignore writes, and they do not count as bad.
- R10: A bad access is any access not covered by R2 to R9, either read or write. It reads zero and changes no register. It raises `bad_pulse` for exactly the following cycle and increments `bad_count` at the same edge. The count saturates at 255, and a cycle with both strobes counts once. Either reset clears the flag and the count.
- R11: `bus_rdata` reflects the state before the current clock edge. A write becomes visible to reads in the cycle after it, and in a cycle with both strobes the read returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Asynchronous warm reset, active low |
| type_reload | input | 1 | Restores the type word to its default at the clock edge |
| bus_addr | input | ADDR_W | Byte address; low 12 bits decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bad_pulse | output | 1 | One-cycle flag after an unmapped access |
| bad_count | output | 8 | Saturating count of unmapped accesses |

## Verification
The hardest state to reach is a type word that has collected bits from several different auxiliary settings. It takes a write to auxiliary control, then a type read, then another write and another read, and a warm reset in between must not disturb it. The stimulus builds this with directed sequences. A long random phase follows, mixing every decoded offset, alias addresses, both resets and reload pulses. Saturation of the bad-access counter is reached by a directed burst of more than 255 unmapped accesses, including cycles with both strobes.

// File: rtl/cache_ctl_stub.sv
module cache_ctl_stub #(
  parameter int          ADDR_W       = 32,
  parameter logic [31:0] ID_VALUE     = 32'h410000C8,
  parameter logic [31:0] TYPE_DEFAULT = 32'h1C100100,
  parameter logic [31:0] AUX_RESET    = 32'h02020000,
  parameter int          CNT_W        = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              type_reload,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bad_pulse,
  output logic [CNT_W-1:0]  bad_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic        arst_n;
  logic [11:0] off;
  logic        ctrl_q;
  logic [31:0] aux_q, tag_q, dat_q, fstart_q, fend_q, type_q;
  logic [4:0]  tcode;
  logic [31:0] type_view;

  logic hit_id, hit_type, hit_ctrl, hit_aux, hit_tag, hit_dat, hit_fs, hit_fe;
  logic hit_maint, hit_quiet, rd_ok, wr_ok, bad_now;

  assign arst_n = por_n & rst_n;
  assign off    = bus_addr[11:0];

  assign hit_id    = off == 12'h000;
  assign hit_type  = off == 12'h004;
  assign hit_ctrl  = off == 12'h100;
  assign hit_aux   = off == 12'h104;
  assign hit_tag   = off == 12'h108;
  assign hit_dat   = off == 12'h10C;
  assign hit_fs    = off == 12'hC00;
  assign hit_fe    = off == 12'hC04;
  assign hit_maint = (off >= 12'h730) && (off < 12'h800);
  assign hit_quiet = (off == 12'hF40) || (off == 12'hF60) || (off == 12'hF80);

  assign wr_ok   = hit_ctrl | hit_aux | hit_tag | hit_dat | hit_fs | hit_fe
                 | hit_maint | hit_quiet;
  assign rd_ok   = wr_ok | hit_id | hit_type;
  assign bad_now = (bus_rd & ~rd_ok) | (bus_wr & ~wr_ok);

  assign tcode     = {aux_q[19:17], 1'b0, aux_q[16]};
  assign type_view = type_q | ({27'd0, tcode} << 18) | ({27'd0, tcode} << 6);

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd) begin
      unique case (1'b1)
        hit_id:   bus_rdata = ID_VALUE;
        hit_type: bus_rdata = type_view;
        hit_ctrl: bus_rdata = {31'd0, ctrl_q};
        hit_aux:  bus_rdata = aux_q;
        hit_tag:  bus_rdata = tag_q;
        hit_dat:  bus_rdata = dat_q;
        hit_fs:   bus_rdata = fstart_q;
        hit_fe:   bus_rdata = fend_q;
        default:  bus_rdata = 32'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                   type_q <= TYPE_DEFAULT;
    else if (type_reload)         type_q <= TYPE_DEFAULT;
    else if (bus_rd && hit_type)  type_q <= type_view;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ctrl_q   <= 1'b0;
      aux_q    <= AUX_RESET;
      tag_q    <= 32'd0;
      dat_q    <= 32'd0;
      fstart_q <= 32'd0;
      fend_q   <= 32'd0;
    end else if (bus_wr) begin
      if (hit_ctrl) ctrl_q   <= bus_wdata[0];
      if (hit_aux)  aux_q    <= bus_wdata;
      if (hit_tag)  tag_q    <= bus_wdata;
      if (hit_dat)  dat_q    <= bus_wdata;
      if (hit_fs)   fstart_q <= bus_wdata;
      if (hit_fe)   fend_q   <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bad_pulse <= 1'b0;
      bad_count <= '0;
    end else begin
      bad_pulse <= bad_now;
      if (bad_now && bad_count != CNT_MAX) bad_count <= bad_count + 1'b1;
    end
  end
endmodule

// File: rtl/cache_ctl_stub_chk.sv
module cache_ctl_stub_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              type_reload,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              bad_pulse,
  input logic [CNT_W-1:0]  bad_count
);
  logic [11:0] off;
  assign off = bus_addr[11:0];

  assert_id_value_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_rd && off == 12'h000) |-> bus_rdata == 32'h410000C8);

  assert_ctrl_upper_zero_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_rd && off == 12'h100) |-> bus_rdata[31:1] == 31'd0);

  assert_maint_done_R8: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_rd && off >= 12'h730 && off < 12'h800) |-> bus_rdata == 32'd0);

  assert_type_sticky_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_rd && off == 12'h004 && $past(bus_rd && off == 12'h004 && !type_reload))
      |-> (bus_rdata & $past(bus_rdata)) == $past(bus_rdata));

  assert_count_saturates_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (&bad_count) |=> (&bad_count));

  assert_count_follows_pulse_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bad_pulse && !(&$past(bad_count))) |-> bad_count == $past(bad_count) + 1'b1);

  assert_count_holds_R10: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !bad_pulse |-> $stable(bad_count));
endmodule

bind cache_ctl_stub cache_ctl_stub_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .type_reload(type_reload),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .bad_pulse(bad_pulse), .bad_count(bad_count));

// File: tb/test_cache_ctl_stub.sv
`timescale 1ns/100ps
module test_cache_ctl_stub;
  localparam logic [31:0] TDEF = 32'h1C100100;

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic        por_n = 0, rst_n = 0, type_reload = 0, bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        bad_pulse;
  logic [7:0]  bad_count;

  cache_ctl_stub i_cache_ctl_stub (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .type_reload(type_reload),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bad_pulse(bad_pulse), .bad_count(bad_count));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit          m_ctrl, m_pulse;
  logic [31:0] m_aux, m_tag, m_dat, m_fs, m_fe, m_type;
  int          m_cnt;

  function automatic logic [31:0] tmask(logic [31:0] a);
    logic [31:0] c;
    c = {27'd0, a[19:17], 1'b0, a[16]};
    return (c << 18) | (c << 6);
  endfunction

  function automatic bit is_maint(logic [11:0] o);
    return o >= 12'h730 && o <= 12'h7FF;
  endfunction

  function automatic bit is_quiet(logic [11:0] o);
    return o == 12'hF40 || o == 12'hF60 || o == 12'hF80;
  endfunction

  function automatic bit is_rw(logic [11:0] o);
    return o == 12'h100 || o == 12'h104 || o == 12'h108 || o == 12'h10C ||
           o == 12'hC00 || o == 12'hC04;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] o);
    case (o)
      12'h000: return 32'h410000C8;
      12'h004: return m_type | tmask(m_aux);
      12'h100: return {31'd0, m_ctrl};
      12'h104: return m_aux;
      12'h108: return m_tag;
      12'h10C: return m_dat;
      12'hC00: return m_fs;
      12'hC04: return m_fe;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_warm();
    m_ctrl = 0; m_aux = 32'h02020000; m_tag = 0; m_dat = 0; m_fs = 0; m_fe = 0;
    m_pulse = 0; m_cnt = 0;
  endtask

  task automatic fail(string tag, string what, logic [31:0] act, logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  // one bus cycle: drive at negedge, compare before next posedge, step model
  task automatic cyc(bit rd, bit wr, logic [31:0] a, logic [31:0] d,
                     bit rl, bit por, bit rst, string tag);
    logic [11:0] o;
    logic [31:0] exp;
    bit          bad;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    type_reload = rl; por_n = por; rst_n = rst;
    o = a[11:0];
    if (!por) m_type = TDEF;
    if (!por || !rst) m_warm();
    #1;
    exp = rd ? m_read(o) : 32'd0;
    checks++;
    if (bus_rdata !== exp) fail(tag, "rdata", bus_rdata, exp);
    else if (bad_pulse !== m_pulse) fail(tag, "bad_pulse", {31'd0, bad_pulse}, {31'd0, m_pulse});
    else if (bad_count !== m_cnt[7:0]) fail(tag, "bad_count", {24'd0, bad_count}, m_cnt);
    // model of the coming edge
    bad = (rd && !(is_rw(o) || is_maint(o) || is_quiet(o) || o == 12'h000 || o == 12'h004)) ||
          (wr && !(is_rw(o) || is_maint(o) || is_quiet(o)));
    if (por) begin
      if (rl) m_type = TDEF;
      else if (rd && o == 12'h004) m_type = m_type | tmask(m_aux);
    end
    if (por && rst) begin
      m_pulse = bad;
      if (bad && m_cnt < 255) m_cnt++;
      if (wr) case (o)
        12'h100: m_ctrl = d[0];
        12'h104: m_aux = d;
        12'h108: m_tag = d;
        12'h10C: m_dat = d;
        12'hC00: m_fs = d;
        12'hC04: m_fe = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d, string tag);
    cyc(0, 1, a, d, 0, 1, 1, tag);
  endtask
  task automatic rd(logic [31:0] a, string tag);
    cyc(1, 0, a, 0, 0, 1, 1, tag);
  endtask
  task automatic idle(string tag);
    cyc(0, 0, 0, 0, 0, 1, 1, tag);
  endtask

  function automatic logic [31:0] pick_addr();
    logic [11:0] offs [14] = '{12'h000, 12'h004, 12'h100, 12'h104, 12'h108, 12'h10C,
                               12'hC00, 12'hC04, 12'h730, 12'h7FC, 12'hF40, 12'hF60,
                               12'hF80, 12'h800};
    logic [31:0] r;
    r = $urandom;
    if (r[3:0] < 14) return {r[31:12], offs[r[3:0]]};
    return r;
  endfunction

  initial begin
    m_type = TDEF; m_warm();
    cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(0, 0, 0, 0, 0, 0, 0, "R7");
    idle("R7");
    // reset state of every register (R7, R3)
    rd(32'h100, "R7"); rd(32'h104, "R7"); rd(32'h108, "R7"); rd(32'h10C, "R7");
    rd(32'hC00, "R7"); rd(32'hC04, "R7");
    rd(32'h000, "R2");
    wr(32'h000, 32'hFFFF_FFFF, "R2"); rd(32'h000, "R2"); idle("R2");
    // type with default aux: aux[19:17]=1, aux[16]=0 -> code 4
    rd(32'h004, "R3");
    rd(32'h004, "R4");
    wr(32'h104, 32'h000F_0000, "R4"); rd(32'h004, "R4");
    wr(32'h104, 32'h0, "R4"); rd(32'h004, "R4");
    // warm reset keeps type, reload restores it
    cyc(0, 0, 0, 0, 0, 1, 0, "R3"); idle("R3"); rd(32'h004, "R3");
    cyc(1, 0, 32'h004, 0, 1, 1, 1, "R3"); rd(32'h004, "R3");
    wr(32'h004, 32'h1234_5678, "R3"); rd(32'h004, "R3");
    // control bit 0 only
    wr(32'h100, 32'hFFFF_FFFE, "R5"); rd(32'h100, "R5");
    wr(32'h100, 32'h8000_0001, "R5"); rd(32'h100, "R5");
    // full registers, aliased addresses
    wr(32'h108, 32'hA5A5_5A5A, "R6"); wr(32'h1000_010C, 32'h0123_4567, "R1");
    wr(32'hC00, 32'hDEAD_BEEF, "R6"); wr(32'hFFFF_FC04, 32'hCAFE_F00D, "R1");
    rd(32'h7777_7108, "R1"); rd(32'h10C, "R6"); rd(32'hC00, "R6"); rd(32'hC04, "R6");
    // same-cycle read and write returns old value
    cyc(1, 1, 32'h108, 32'h1111_2222, 0, 1, 1, "R11"); rd(32'h108, "R11");
    // maintenance range
    wr(32'h730, 32'hFFFF_FFFF, "R8"); rd(32'h730, "R8"); rd(32'h7FF, "R8");
    wr(32'h7FC, 32'h1, "R8"); rd(32'h100, "R8"); idle("R8");
    // quiet offsets
    wr(32'hF40, 1, "R9"); rd(32'hF60, "R9"); cyc(1, 1, 32'hF80, 5, 0, 1, 1, "R9"); idle("R9");
    // unmapped
    rd(32'h800, "R10"); rd(32'h72C, "R10"); wr(32'h110, 32'h5, "R10"); idle("R10");
    rd(32'h100, "R10");
    for (int i = 0; i < 130; i++) cyc(1, 1, 32'hABC, 0, 0, 1, 1, "R10");
    for (int i = 0; i < 140; i++) wr(32'h0, i, "R10");
    idle("R10"); idle("R10");
    cyc(0, 0, 0, 0, 0, 1, 0, "R10"); idle("R10");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1], pick_addr(), $urandom, r[7:2] == 0,
          r[15:8] != 0, r[23:16] != 0, "R1");
    end
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule